// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Length

This block turns bytes written by a host into asynchronous serial frames on a single line. Each frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and a stop period. The stop period can be set between one and two bit times in sixteenth-bit steps. All timing comes from an external enable pulse that arrives sixteen times per bit time. The block has a one-byte holding register in front of the shift register. A ready flag tells the host when the next byte can be written. A character written while one is already shifting leaves with no gap after the running stop period.

A host command can force the line to space as a line break. The break begins once any character already in progress has finished, and it lasts until a second command ends it. A channel mode input picks one of four loop arrangements. In normal mode the transmitter drives the line. In automatic echo the incoming line is repeated onto the outgoing line. In local loopback the transmitter output is turned inward to the receiver path and the line is held at mark. In remote loopback the incoming line is repeated outward and the receiver path is held at mark.

Top module: `frame_tx`

## Requirements
- R1: Reset is synchronous and active high. After reset, `tx_ready` = 1, `txd_out` = 1 and `rx_path` = 1.
- R2: A frame opens with a start bit at 0. The data bits follow, least significant bit first. Every bit, the start bit included, lasts exactly 16 `tick16` pulses.
- R3: `len_code` selects the data length as 5 + `len_code` bits (0 gives 5 bits, 3 gives 8). Byte bits above the selected length are not sent.
- R4: `par_mode` controls the parity bit that follows the data. The encodings are:
  - 0: no parity bit.
  - 1: even, so the data bits plus the parity bit hold an even number of ones.
  - 2: odd, so the data bits plus the parity bit hold an odd number of ones.
  - 3: the parity bit equals `par_lvl`.
- R5: The stop period is high for 16 + min(`stop_frac`, 16) ticks, which covers one to two bit times. When a byte is already held, its start bit follows the stop period directly.
- R6: `tx_ready` is high while the holding register is empty. A write while it is high clears it on the next cycle. It rises again when the held byte moves into the shifter, which is also when that byte's start bit begins. A write while it is low is dropped.
- R7: While `tx_en` is low, no new frame or break starts, the line stays at mark, and a held byte stays held.
- R8: A `brk_start` pulse drives the line to 0 once the frame in progress has ended, and the break persists until a `brk_stop` pulse. After that pulse the line returns to 1.
- R9: When `loop_mode` = 1 (automatic echo), `txd_out` and `rx_path` both follow `rxd_in` one cycle later.
- R10: When `loop_mode` = 2 (local loopback), `txd_out` stays at 1 and `rx_path` carries the transmitter's serial frames.
- R11: When `loop_mode` = 3 (remote loopback), `txd_out` follows `rxd_in` one cycle later and `rx_path` stays at 1.
- R12: When `loop_mode` = 0 (normal), `txd_out` carries the frames and sits at 1 while the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse, sixteen per bit time |
| tx_en | input | 1 | Transmitter enable |
| wr_valid | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Byte to send |
| tx_ready | output | 1 | Holding register empty |
| len_code | input | 2 | Data length code (5 + code bits) |
| par_mode | input | 2 | Parity selection |
| par_lvl | input | 1 | Parity value when parity is fixed |
| stop_frac | input | $clog2(OVS)+1 | Extra stop length in sixteenths |
| loop_mode | input | 2 | Channel loop arrangement |
| brk_start | input | 1 | Start-break command pulse |
| brk_stop | input | 1 | Stop-break command pulse |
| rxd_in | input | 1 | Incoming serial line |
| txd_out | output | 1 | Outgoing serial line |
| rx_path | output | 1 | Serial stream handed to the receiver |

## Verification
The bench decodes the line once per tick and compares every tick of each frame against a frame built from the requirements. It sends random back-to-back byte pairs with random lengths, parities and stop lengths, including stop values above 16. A design that counted the stop period wrong, or inserted an idle tick between characters, would shift the second start bit and fail there. A design that sent bits above the selected length, or took parity over them, would show a wrong bit inside the frame.

Writes issued while the transmitter is disabled, including one made while the register is full, are checked for being held and dropped respectively. A break requested during a character is checked for leaving that character intact before the line goes to space. Each loop mode is driven with random line activity to catch a swapped or missing path.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  typedef enum logic [1:0] {
    LM_NORMAL = 2'd0,
    LM_ECHO   = 2'd1,
    LM_LOCAL  = 2'd2,
    LM_REMOTE = 2'd3
  } loop_mode_e;

  typedef enum logic [1:0] {
    PM_NONE  = 2'd0,
    PM_EVEN  = 2'd1,
    PM_ODD   = 2'd2,
    PM_FIXED = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_BREAK = 3'd5
  } tx_state_e;

  localparam int LEN_W = 2;

endpackage

// File: rtl/frame_tx_hold.sv
module frame_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (take) begin
      hold_full <= 1'b0;
    end else if (wr_valid && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end
  end

  // R6
  write_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !hold_full) |=> hold_full);

  // R6
  take_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> hold_full);

  // R6
  full_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !take) |=> $stable(hold_data));

endmodule

// File: rtl/frame_tx_shift.sv
module frame_tx_shift
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   tx_en,
  input  logic                   hold_full,
  input  logic [DATA_W-1:0]      hold_data,
  input  logic [LEN_W-1:0]       len_code,
  input  logic [1:0]             par_mode,
  input  logic                   par_lvl,
  input  logic [$clog2(OVS):0]   stop_frac,
  input  logic                   brk_start,
  input  logic                   brk_stop,
  output logic                   take,
  output logic                   ser
);

  localparam int CNT_W = $clog2(2 * OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int SL_W  = $clog2(OVS) + 1;

  tx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_en_q;
  logic              par_bit_q;
  logic [CNT_W-1:0]  stop_last;
  logic              brk_req;

  logic              start_ok;
  logic              brk_go;
  logic              bit_end;
  logic              stop_end;
  logic [IDX_W-1:0]  last_idx_nx;
  logic [SL_W-1:0]   frac_clip;
  logic              par_calc;
  par_mode_e         pm;

  always_comb begin
    pm          = par_mode_e'(par_mode);
    start_ok    = tx_en && hold_full && !brk_req;
    brk_go      = tx_en && brk_req;
    bit_end     = tick && (cnt == CNT_W'(OVS - 1));
    stop_end    = tick && (cnt == stop_last);
    take        = start_ok && tick &&
                  ((state == ST_IDLE) || (state == ST_STOP && cnt == stop_last));
    last_idx_nx = IDX_W'(DATA_W - 4) + IDX_W'(len_code);
    frac_clip   = (stop_frac > SL_W'(OVS)) ? SL_W'(OVS) : stop_frac;
    par_calc    = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (IDX_W'(i) <= last_idx_nx) par_calc = par_calc ^ hold_data[i];
    end
  end

  // frame settings captured when a byte enters the shifter
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      last_idx  <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      stop_last <= CNT_W'(OVS - 1);
    end else if (take) begin
      shreg     <= hold_data;
      last_idx  <= last_idx_nx;
      par_en_q  <= (pm != PM_NONE);
      stop_last <= CNT_W'(OVS - 1) + CNT_W'(frac_clip);
      case (pm)
        PM_EVEN:  par_bit_q <= par_calc;
        PM_ODD:   par_bit_q <= ~par_calc;
        PM_FIXED: par_bit_q <= par_lvl;
        default:  par_bit_q <= 1'b0;
      endcase
    end else if (state == ST_DATA && bit_end) begin
      shreg <= shreg >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            brk_req <= 1'b0;
    else if (brk_stop)  brk_req <= 1'b0;
    else if (brk_start) brk_req <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (tick) begin
            if (brk_go)        state <= ST_BREAK;
            else if (start_ok) state <= ST_START;
          end
        end
        ST_START: begin
          if (bit_end) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= ST_DATA;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (bit_idx == last_idx) state <= par_en_q ? ST_PAR : ST_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (stop_end) begin
            cnt <= '0;
            if (brk_go)        state <= ST_BREAK;
            else if (start_ok) state <= ST_START;
            else               state <= ST_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BREAK: begin
          cnt <= '0;
          if (brk_stop) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START: ser = 1'b0;
      ST_DATA:  ser = shreg[0];
      ST_PAR:   ser = par_bit_q;
      ST_BREAK: ser = 1'b0;
      default:  ser = 1'b1;
    endcase
  end

  // R8
  brk_after_char_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BREAK && $past(state) != ST_BREAK) |->
      ($past(state) == ST_IDLE || $past(state) == ST_STOP));

  // R7
  start_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && $past(state) != ST_START) |-> $past(tx_en));

  // R2
  bit_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START || state == ST_DATA || state == ST_PAR) |-> (cnt < CNT_W'(OVS)));

  // R5
  stop_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP) |-> (cnt <= stop_last));

endmodule

// File: rtl/frame_tx_loop.sv
module frame_tx_loop
  import frame_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] loop_mode,
  input  logic       ser,
  input  logic       rxd_in,
  output logic       txd_out,
  output logic       rx_path
);

  loop_mode_e lm;
  assign lm = loop_mode_e'(loop_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_out <= 1'b1;
      rx_path <= 1'b1;
    end else begin
      case (lm)
        LM_ECHO: begin
          txd_out <= rxd_in;
          rx_path <= rxd_in;
        end
        LM_LOCAL: begin
          txd_out <= 1'b1;
          rx_path <= ser;
        end
        LM_REMOTE: begin
          txd_out <= rxd_in;
          rx_path <= 1'b1;
        end
        default: begin
          txd_out <= ser;
          rx_path <= rxd_in;
        end
      endcase
    end
  end

  // R9
  echo_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (lm == LM_ECHO) |=> (txd_out == $past(rxd_in) && rx_path == $past(rxd_in)));

  // R10
  local_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (lm == LM_LOCAL) |=> txd_out);

  // R11
  remote_iso_chk: assert property (@(posedge clk) disable iff (rst)
    (lm == LM_REMOTE) |=> (rx_path && txd_out == $past(rxd_in)));

endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick16,
  input  logic                 tx_en,
  input  logic                 wr_valid,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 tx_ready,
  input  logic [1:0]           len_code,
  input  logic [1:0]           par_mode,
  input  logic                 par_lvl,
  input  logic [$clog2(OVS):0] stop_frac,
  input  logic [1:0]           loop_mode,
  input  logic                 brk_start,
  input  logic                 brk_stop,
  input  logic                 rxd_in,
  output logic                 txd_out,
  output logic                 rx_path
);

  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              take;
  logic              ser;

  frame_tx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .take      (take),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  frame_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) shift_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick16),
    .tx_en     (tx_en),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .len_code  (len_code),
    .par_mode  (par_mode),
    .par_lvl   (par_lvl),
    .stop_frac (stop_frac),
    .brk_start (brk_start),
    .brk_stop  (brk_stop),
    .take      (take),
    .ser       (ser)
  );

  frame_tx_loop loop_i (
    .clk       (clk),
    .rst       (rst),
    .loop_mode (loop_mode),
    .ser       (ser),
    .rxd_in    (rxd_in),
    .txd_out   (txd_out),
    .rx_path   (rx_path)
  );

  assign tx_ready = ~hold_full;

endmodule

// File: tb/frame_tx_tb_top.sv
module frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       tx_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_ready;
  logic [1:0] len_code = 2'd3;
  logic [1:0] par_mode = 2'd0;
  logic       par_lvl = 1'b0;
  logic [4:0] stop_frac = '0;
  logic [1:0] loop_mode = 2'd0;
  logic       brk_start = 1'b0;
  logic       brk_stop = 1'b0;
  logic       rxd_in = 1'b1;
  logic       txd_out;
  logic       rx_path;

  int total = 0;
  int bad   = 0;
  int tdiv  = 0;

  frame_tx #(.DATA_W(8), .OVS(16)) dut_i (
    .clk(clk), .rst(rst), .tick16(tick16), .tx_en(tx_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .tx_ready(tx_ready),
    .len_code(len_code), .par_mode(par_mode), .par_lvl(par_lvl),
    .stop_frac(stop_frac), .loop_mode(loop_mode),
    .brk_start(brk_start), .brk_stop(brk_stop),
    .rxd_in(rxd_in), .txd_out(txd_out), .rx_path(rx_path)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 2);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  task automatic get_sample(output bit t, output bit r);
    do @(negedge clk); while (!tick16);
    t = txd_out;
    r = rx_path;
  endtask

  function automatic bit lvl_at(input int i, input logic [7:0] d, input int nb,
                                input int pm, input bit pl);
    int seg;
    bit p;
    seg = i / 16;
    if (seg == 0) return 1'b0;
    if (seg <= nb) return d[seg-1];
    if (pm != 0 && seg == nb + 1) begin
      p = 1'b0;
      for (int k = 0; k < nb; k++) p = p ^ d[k];
      if (pm == 1) return p;
      if (pm == 2) return ~p;
      return pl;
    end
    return 1'b1;
  endfunction

  task automatic expect_frame(input logic [7:0] d, input int nb, input int pm,
                              input bit pl, input int sl, input bit use_rx,
                              input bit immediate, input bit other_mark,
                              input string tag);
    bit t, r, s, o;
    int len, waitn, err_i, err_a, err_e, oth_err;
    len = 16 * (1 + nb + ((pm != 0) ? 1 : 0)) + 16 + ((sl > 16) ? 16 : sl);
    err_i = -1; err_a = 0; err_e = 0; oth_err = 0; waitn = 0;
    get_sample(t, r);
    s = use_rx ? r : t;
    o = use_rx ? t : r;
    if (other_mark && !o) oth_err++;
    if (!immediate) begin
      while (s && waitn < 3000) begin
        get_sample(t, r);
        s = use_rx ? r : t;
        o = use_rx ? t : r;
        if (other_mark && !o) oth_err++;
        waitn++;
      end
      if (waitn >= 3000) begin
        chk(1'b0, {tag, " no start bit"}, 1, 0);
        return;
      end
    end
    for (int i = 0; i < len; i++) begin
      if (i > 0) begin
        get_sample(t, r);
        s = use_rx ? r : t;
        o = use_rx ? t : r;
        if (other_mark && !o) oth_err++;
      end
      if (err_i < 0 && s != lvl_at(i, d, nb, pm, pl)) begin
        err_i = i; err_a = s; err_e = lvl_at(i, d, nb, pm, pl);
      end
    end
    if (err_i >= 0) $display("  mismatch at tick %0d of frame %s", err_i, tag);
    chk(err_i < 0, tag, err_a, err_e);
    if (other_mark) chk(oth_err == 0, {tag, " other path not mark"}, oth_err, 0);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic count_level(input int n, input bit lvl, input bit use_rx, output int miss);
    bit t, r;
    miss = 0;
    for (int i = 0; i < n; i++) begin
      get_sample(t, r);
      if ((use_rx ? r : t) != lvl) miss++;
    end
  endtask

  initial begin
    int unsigned seed_v;
    int miss, nb, pm, sl;
    bit pl, prev;
    logic [7:0] d1, d2;
    seed_v = $urandom(32'h2681);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tx_ready == 1'b1, "R1 tx_ready after reset", tx_ready, 1);
    chk(txd_out == 1'b1, "R1 txd_out after reset", txd_out, 1);
    chk(rx_path == 1'b1, "R1 rx_path after reset", rx_path, 1);

    // R2 R6 directed frame, 8 bits, no parity, one stop bit
    tx_en = 1'b1;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hA5;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(tx_ready == 1'b0, "R6 ready cleared by write", tx_ready, 0);
    expect_frame(8'hA5, 8, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R2 frame A5");
    chk(tx_ready == 1'b1, "R6 ready set after load", tx_ready, 1);

    // R3 R4 R5 random back-to-back pairs
    for (int it = 0; it < 12; it++) begin
      @(negedge clk);
      len_code  = 2'($urandom % 4);
      par_mode  = 2'($urandom % 4);
      par_lvl   = 1'($urandom % 2);
      stop_frac = 5'($urandom % 21);
      if (it == 0) stop_frac = 5'd8;
      if (it == 1) stop_frac = 5'd16;
      if (it == 2) stop_frac = 5'd20;
      nb = 5 + int'(len_code);
      pm = int'(par_mode);
      pl = par_lvl;
      sl = int'(stop_frac);
      d1 = 8'($urandom);
      d2 = 8'($urandom);
      fork
        begin
          write_byte(d1);
          write_byte(d2);
        end
      join_none
      expect_frame(d1, nb, pm, pl, sl, 1'b0, 1'b0, 1'b0, "R3 R4 first of pair");
      expect_frame(d2, nb, pm, pl, sl, 1'b0, 1'b1, 1'b0, "R5 second of pair back to back");
      count_level(4, 1'b1, 1'b0, miss);
      chk(miss == 0, "R12 idle mark after pair", miss, 0);
    end

    // R6 R7 disabled transmitter, dropped second write
    @(negedge clk);
    len_code = 2'd3; par_mode = 2'd0; stop_frac = 5'd0;
    tx_en = 1'b0;
    wr_valid = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    chk(tx_ready == 1'b0, "R6 ready low after write", tx_ready, 0);
    wr_data = 8'hC3;
    @(negedge clk);
    wr_valid = 1'b0;
    count_level(40, 1'b1, 1'b0, miss);
    chk(miss == 0, "R7 line mark while disabled", miss, 0);
    chk(tx_ready == 1'b0, "R7 byte stays held while disabled", tx_ready, 0);
    @(negedge clk);
    tx_en = 1'b1;
    expect_frame(8'h3C, 8, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R6 held byte sent, full write dropped");
    count_level(40, 1'b1, 1'b0, miss);
    chk(miss == 0, "R6 R12 no frame from dropped write", miss, 0);

    // R8 break after the character in progress
    write_byte(8'h55);
    while (!tx_ready) @(negedge clk);
    brk_start = 1'b1;
    @(negedge clk);
    brk_start = 1'b0;
    expect_frame(8'h55, 8, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R8 char finishes before break");
    count_level(50, 1'b0, 1'b0, miss);
    chk(miss == 0, "R8 line held at space", miss, 0);
    @(negedge clk);
    brk_stop = 1'b1;
    @(negedge clk);
    brk_stop = 1'b0;
    count_level(5, 1'b1, 1'b0, miss);
    chk(miss == 0, "R8 mark after stop break", miss, 0);

    // R9 automatic echo
    @(negedge clk);
    loop_mode = 2'd1;
    @(negedge clk);
    miss = 0;
    prev = 1'b1;
    for (int i = 0; i < 32; i++) begin
      prev = 1'($urandom % 2);
      rxd_in = prev;
      @(negedge clk);
      if (txd_out != prev || rx_path != prev) miss++;
    end
    chk(miss == 0, "R9 echo follows input", miss, 0);
    rxd_in = 1'b1;

    // R10 local loopback
    @(negedge clk);
    loop_mode = 2'd2;
    len_code = 2'd1; par_mode = 2'd2; stop_frac = 5'd8;
    repeat (2) @(negedge clk);
    write_byte(8'hD9);
    expect_frame(8'hD9, 6, 2, 1'b0, 8, 1'b1, 1'b0, 1'b1, "R10 local loop frame on rx_path");

    // R11 remote loopback
    @(negedge clk);
    loop_mode = 2'd3;
    @(negedge clk);
    write_byte(8'h96);
    miss = 0;
    for (int i = 0; i < 200; i++) begin
      prev = 1'($urandom % 2);
      rxd_in = prev;
      @(negedge clk);
      if (txd_out != prev || rx_path != 1'b1) miss++;
    end
    chk(miss == 0, "R11 remote repeats line, receiver isolated", miss, 0);
    rxd_in = 1'b1;
    count_level(300, 1'b1, 1'b1, miss);
    chk(miss == 0, "R11 rx_path mark in remote", miss, 0);
    @(negedge clk);
    loop_mode = 2'd0;
    repeat (4) @(negedge clk);
    chk(txd_out == 1'b1, "R12 normal idle mark", txd_out, 1);

    finish_up();
  end

endmodule